// File: doc/BRIEF.md
# PCM Serial Port

This block moves stereo PCM samples between a sample FIFO and a single serial data pin. An external master supplies the bit clock and the frame clock; the block oversamples both with its own system clock, finds their edges and, in transmit mode, launches one data bit per bit period and takes one word from the FIFO at each slot start. In receive mode it samples the data pin, assembles each word and pushes it with a tag that tells which channel it belongs to.

A handful of static control inputs pick the framing (standard I2S with its one-bit delay, or left-justified), which bit-clock edge launches data, the sense of the frame clock, the word length (16, 20 or 24 bits) and the direction. Two one-cycle flags report a missing transmit word and a received word that found the FIFO full. Clock generation and software registers live elsewhere. Control inputs are expected to change only while the block is held in reset.

Top module: `pcm_serial_port`

## Requirements
- R1: During and right after reset, txdOut is low and txPop, rxPush, underflowPulse and overflowPulse are all low.
- R2: With delayMode low (left-justified), the frame clock high marks the left slot when fclkInvert is low, and the word's MSB is on the pin in the bit period that begins at the frame-clock transition; bits follow MSB first.
- R3: With delayMode high (I2S), the frame clock low marks the left slot when fclkInvert is low, and the MSB is on the pin one bit period after the frame-clock transition.
- R4: With bclkInvert low, data and frame clock change on the falling bit-clock edge and are sampled on the rising one; with bclkInvert high the two edges swap.
- R5: fclkInvert high inverts the frame-clock level that marks the left slot in either framing.
- R6: wordLen code 0 selects 16-bit words, 4 selects 20 and 8 selects 24 (any other code acts as 16); samples sit right-aligned in the 24-bit FIFO word.
- R7: With readMode low, exactly one txPop pulse occurs per slot start while txValid is high, and slot bits after the word are driven low; nothing is popped before the first frame-clock transition.
- R8: With readMode low and txValid low at a slot start, underflowPulse rises for one cycle, nothing is popped and the previous word is sent again in that slot.
- R9: With readMode high, one rxPush per slot carries the received word, right-aligned, and rxLeft tells its channel; slot bits after the word are ignored, txdOut stays low and txPop never pulses.
- R10: With readMode high and rxFull high when a word completes, overflowPulse rises for one cycle and no rxPush occurs for that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Bit clock from the external master |
| fclkIn | input | 1 | Frame (channel select) clock from the external master |
| rxdIn | input | 1 | Serial data in (receive) |
| txdOut | output | 1 | Serial data out (transmit) |
| delayMode | input | 1 | 1: I2S one-bit delay, 0: left-justified |
| bclkInvert | input | 1 | Swap launch and sample bit-clock edges |
| fclkInvert | input | 1 | Invert the frame-clock sense |
| wordLen | input | 4 | Word length code: 0=16, 4=20, 8=24 bits |
| readMode | input | 1 | 0: transmit, 1: receive |
| txSample | input | 24 | Transmit FIFO head word, right-aligned |
| txValid | input | 1 | Transmit FIFO not empty |
| txPop | output | 1 | Takes the head word in this cycle |
| rxSample | output | 24 | Received word, right-aligned |
| rxLeft | output | 1 | Received word belongs to the left slot |
| rxPush | output | 1 | rxSample and rxLeft valid this cycle |
| rxFull | input | 1 | Receive FIFO full |
| underflowPulse | output | 1 | Transmit word missing at a slot start |
| overflowPulse | output | 1 | Received word dropped, FIFO full |

## Verification
A bit-clock edge reaches the logic through a two-stage synchronizer and an edge register, so a transmitted bit reaches txdOut about five system cycles after the launch edge, and txPop, underflowPulse, rxPush and overflowPulse appear four to five cycles after the edge that caused them. The bench holds each bit-clock half period for eight system cycles and samples txdOut only at the end of the launch half, just before the sampling edge, so every bit has settled. Pulses are counted over whole slots rather than at single cycles, and words are compared after the slot that carries them has finished.

// File: rtl/pcm_serial_pkg.sv
package pcm_serial_pkg;
  parameter int SAMPLE_W   = 24;
  parameter int SLOT_CNT_W = 6;
  localparam int SEL_W     = $clog2(SAMPLE_W);

  // Strobes from the control to the datapath, one system cycle wide.
  typedef struct packed {
    logic             launch;
    logic             sample;
    logic             slotStart;
    logic             leftSlot;
    logic             bitValid;
    logic             lastBit;
    logic [SEL_W-1:0] bitSel;
    logic             rxBit;
  } strobe_t;

  localparam logic [SLOT_CNT_W-1:0] LEN16 = SLOT_CNT_W'(16);
  localparam logic [SLOT_CNT_W-1:0] LEN20 = SLOT_CNT_W'(20);
  localparam logic [SLOT_CNT_W-1:0] LEN24 = SLOT_CNT_W'(24);

  function automatic logic [SLOT_CNT_W-1:0] wordBitsOf(input logic [3:0] code);
    case (code)
      4'd4:    return LEN20;
      4'd8:    return LEN24;
      default: return LEN16;
    endcase
  endfunction
endpackage

// File: rtl/pcm_serial_ctrl.sv
module pcm_serial_ctrl
  import pcm_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkIn,
  input  logic       fclkIn,
  input  logic       rxdIn,
  input  logic       delayMode,
  input  logic       bclkInvert,
  input  logic       fclkInvert,
  input  logic [3:0] wordLen,
  output strobe_t    strobes
);
  localparam logic [SLOT_CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] bSync, fSync, dSync;
  logic bNow, fNow, dNow, bPrev;
  logic primed, locked, fLast, leftQ;
  logic launchQ, sampleQ, startQ, rxBitQ;
  logic [SLOT_CNT_W-1:0] cnt;

  // All three pins pass through equal-depth synchronizers so that a frame
  // or data change made at a bit-clock edge is seen together with that edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      fSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], bclkIn};
      fSync <= {fSync[SYNC_STAGES-2:0], fclkIn};
      dSync <= {dSync[SYNC_STAGES-2:0], rxdIn};
    end
  end

  assign bNow = bSync[SYNC_STAGES-1];
  assign fNow = fSync[SYNC_STAGES-1];
  assign dNow = dSync[SYNC_STAGES-1];

  logic riseEdge, fallEdge, launch, sample, frameEdge, leftLevel;
  assign riseEdge  = bNow & ~bPrev;
  assign fallEdge  = ~bNow & bPrev;
  assign launch    = bclkInvert ? riseEdge : fallEdge;
  assign sample    = bclkInvert ? fallEdge : riseEdge;
  assign frameEdge = launch & primed & (fNow != fLast);
  assign leftLevel = ~delayMode ^ fclkInvert;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev   <= 1'b0;
      primed  <= 1'b0;
      locked  <= 1'b0;
      fLast   <= 1'b0;
      leftQ   <= 1'b0;
      cnt     <= CNT_MAX;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
      startQ  <= 1'b0;
      rxBitQ  <= 1'b0;
    end else begin
      bPrev   <= bNow;
      launchQ <= launch;
      sampleQ <= sample;
      startQ  <= frameEdge;
      rxBitQ  <= dNow;
      if (launch) begin
        primed <= 1'b1;
        fLast  <= fNow;
        if (frameEdge) begin
          cnt    <= '0;
          locked <= 1'b1;
          leftQ  <= (fNow == leftLevel);
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // Bit position inside the word for the bit period now in progress.
  logic [SLOT_CNT_W-1:0] wordBits, delayExt, dPos, selFull;
  logic inWord;
  assign wordBits = wordBitsOf(wordLen);
  assign delayExt = {{(SLOT_CNT_W-1){1'b0}}, delayMode};
  assign dPos     = cnt - delayExt;
  assign inWord   = locked && (cnt >= delayExt) && (dPos < wordBits);
  assign selFull  = wordBits - SLOT_CNT_W'(1) - dPos;

  always_comb begin
    strobes.launch    = launchQ;
    strobes.sample    = sampleQ;
    strobes.slotStart = startQ;
    strobes.leftSlot  = leftQ;
    strobes.bitValid  = inWord;
    strobes.lastBit   = inWord && (dPos == wordBits - SLOT_CNT_W'(1));
    strobes.bitSel    = selFull[SEL_W-1:0];
    strobes.rxBit     = rxBitQ;
  end

  // R7: a slot can start only after the counter has been primed by a launch
  assert_lock_after_prime_R7: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> locked && cnt == '0);
endmodule

// File: rtl/pcm_serial_datapath.sv
module pcm_serial_datapath
  import pcm_serial_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic                readMode,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic                txValid,
  input  logic                rxFull,
  output logic                txdOut,
  output logic                txPop,
  output logic                underflowPulse,
  output logic [SAMPLE_W-1:0] rxSample,
  output logic                rxLeft,
  output logic                rxPush,
  output logic                overflowPulse
);
  logic [SAMPLE_W-1:0] txWord, nextWord, shiftQ, shiftNext;
  logic txStart, loadNow;

  assign txStart   = ~readMode & strobes.launch & strobes.slotStart;
  assign loadNow   = txStart & txValid;
  assign nextWord  = loadNow ? txSample : txWord;
  assign shiftNext = {shiftQ[SAMPLE_W-2:0], strobes.rxBit};
  assign txPop     = loadNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWord         <= '0;
      txdOut         <= 1'b0;
      underflowPulse <= 1'b0;
      shiftQ         <= '0;
      rxSample       <= '0;
      rxLeft         <= 1'b0;
      rxPush         <= 1'b0;
      overflowPulse  <= 1'b0;
    end else begin
      underflowPulse <= txStart & ~txValid;
      rxPush         <= 1'b0;
      overflowPulse  <= 1'b0;
      if (loadNow) txWord <= txSample;
      if (readMode) begin
        txdOut <= 1'b0;
      end else if (strobes.launch) begin
        txdOut <= strobes.bitValid ? nextWord[strobes.bitSel] : 1'b0;
      end
      if (readMode && strobes.launch && strobes.slotStart) begin
        shiftQ <= '0;
      end else if (readMode && strobes.sample && strobes.bitValid) begin
        shiftQ <= shiftNext;
        if (strobes.lastBit) begin
          if (rxFull) begin
            overflowPulse <= 1'b1;
          end else begin
            rxPush   <= 1'b1;
            rxSample <= shiftNext;
            rxLeft   <= strobes.leftSlot;
          end
        end
      end
    end
  end

  // R9: the data pin stays quiet while receiving
  assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    readMode |=> !txdOut);
  // R10: a push only follows a cycle in which the FIFO had room
  assert_push_not_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> $past(!rxFull));
  // R10: a dropped word never shows up as a push
  assert_no_overflow_push_R10: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> !rxPush);
  // R8: an underflow leaves the held word untouched
  assert_underflow_keeps_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowPulse |-> txWord == $past(txWord));
  // R7: at most one pop per slot start
  assert_single_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> !txPop);
  // R9: one push per completed word
  assert_single_push_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> !rxPush);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclkIn,
  input  logic                fclkIn,
  input  logic                rxdIn,
  output logic                txdOut,
  input  logic                delayMode,
  input  logic                bclkInvert,
  input  logic                fclkInvert,
  input  logic [3:0]          wordLen,
  input  logic                readMode,
  input  logic [SAMPLE_W-1:0] txSample,
  input  logic                txValid,
  output logic                txPop,
  output logic [SAMPLE_W-1:0] rxSample,
  output logic                rxLeft,
  output logic                rxPush,
  input  logic                rxFull,
  output logic                underflowPulse,
  output logic                overflowPulse
);
  strobe_t strobes;

  pcm_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .bclkIn     (bclkIn),
    .fclkIn     (fclkIn),
    .rxdIn      (rxdIn),
    .delayMode  (delayMode),
    .bclkInvert (bclkInvert),
    .fclkInvert (fclkInvert),
    .wordLen    (wordLen),
    .strobes    (strobes)
  );

  pcm_serial_datapath uData (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .readMode       (readMode),
    .txSample       (txSample),
    .txValid        (txValid),
    .rxFull         (rxFull),
    .txdOut         (txdOut),
    .txPop          (txPop),
    .underflowPulse (underflowPulse),
    .rxSample       (rxSample),
    .rxLeft         (rxLeft),
    .rxPush         (rxPush),
    .overflowPulse  (overflowPulse)
  );

  // R1: nothing leaves the block in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rstN) |-> !txPop && !rxPush && !underflowPulse && !overflowPulse && !txdOut);
endmodule

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic bclkPin = 1'b0, fclkPin = 1'b0, rxdPin = 1'b0;
  logic cfgDelay = 1'b0, cfgBinv = 1'b0, cfgFinv = 1'b0, cfgRead = 1'b0, rxFull = 1'b0;
  logic [3:0] cfgLen = 4'd0;
  logic txdOut, txPop, rxLeft, rxPush, underflowPulse, overflowPulse;
  logic [23:0] txSample, rxSample;
  logic txValid;

  int checks = 0, errors = 0;
  int popCnt = 0, uflCnt = 0, oflCnt = 0, pushCnt = 0;
  int popBase = 0, pushBase = 0, txLen = 0, trailBad = 0;
  logic trailOne = 1'b0;
  logic [23:0] txQ [0:7];
  logic [23:0] rxDrv [0:7];
  logic [23:0] capTx [0:7];
  logic [23:0] pushWord [0:15];
  logic pushLeft [0:15];

  assign txValid  = (popCnt - popBase) < txLen;
  assign txSample = txQ[(popCnt - popBase) & 7];

  pcm_serial_port u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclkPin), .fclkIn(fclkPin), .rxdIn(rxdPin),
    .txdOut(txdOut), .delayMode(cfgDelay), .bclkInvert(cfgBinv), .fclkInvert(cfgFinv),
    .wordLen(cfgLen), .readMode(cfgRead), .txSample(txSample), .txValid(txValid),
    .txPop(txPop), .rxSample(rxSample), .rxLeft(rxLeft), .rxPush(rxPush),
    .rxFull(rxFull), .underflowPulse(underflowPulse), .overflowPulse(overflowPulse)
  );

  always @(posedge clk) begin
    if (txPop) popCnt <= popCnt + 1;
    if (underflowPulse) uflCnt <= uflCnt + 1;
    if (overflowPulse) oflCnt <= oflCnt + 1;
    if (rxPush) begin
      pushWord[(pushCnt - pushBase) & 15] <= rxSample;
      pushLeft[(pushCnt - pushBase) & 15] <= rxLeft;
      pushCnt <= pushCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wlBits(input logic [3:0] code);
    return (code == 4'd4) ? 20 : (code == 4'd8) ? 24 : 16;
  endfunction

  // Configure while the block is held in reset; the frame clock rests at the right-slot level.
  task automatic setup(input logic dly, input logic binv, input logic finv, input logic [3:0] len, input logic rd);
    @(negedge clk);
    rstN = 1'b0;
    cfgDelay = dly; cfgBinv = binv; cfgFinv = finv; cfgLen = len; cfgRead = rd;
    bclkPin = 1'b1 ^ binv;
    fclkPin = ~(~dly ^ finv);
    rxdPin = 1'b0;
    rxFull = 1'b0;
    trailOne = 1'b0;
    trailBad = 0;
    txLen = 0;
    popBase = popCnt;
    pushBase = pushCnt;
    for (int i = 0; i < 8; i++) capTx[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One 32-bit slot; s < 0 is an idle preamble slot at the right-slot level.
  task automatic playSlot(input int s);
    int wl;
    logic leftLvl, lvl;
    wl = wlBits(cfgLen);
    leftLvl = ~cfgDelay ^ cfgFinv;
    lvl = (s >= 0 && (s % 2) == 0) ? leftLvl : ~leftLvl;
    for (int b = 0; b < 32; b++) begin
      int d;
      bit data;
      d = b - int'(cfgDelay);
      data = (s >= 0) && (d >= 0) && (d < wl);
      bclkPin = 1'b0 ^ cfgBinv;
      fclkPin = lvl;
      rxdPin = data ? rxDrv[s][wl-1-d] : ((s >= 0) ? trailOne : 1'b0);
      repeat (HALF) @(negedge clk);
      if (s >= 0) begin
        if (!cfgRead && data) capTx[s][wl-1-d] = txdOut;
        else if (txdOut) trailBad++;
      end
      bclkPin = 1'b1 ^ cfgBinv;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic runSlots(input int n);
    playSlot(-1);
    for (int s = 0; s < n; s++) playSlot(s);
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(txdOut == 1'b0, "R1 txdOut in reset", 32'(txdOut), 0);
    check(txPop == 1'b0, "R1 txPop in reset", 32'(txPop), 0);
    check(rxPush == 1'b0, "R1 rxPush in reset", 32'(rxPush), 0);
    check(underflowPulse == 1'b0 && overflowPulse == 1'b0, "R1 flags in reset",
          32'({underflowPulse, overflowPulse}), 0);
  endtask

  task automatic testTxLeftJust16();
    setup(1'b0, 1'b0, 1'b0, 4'd0, 1'b0);
    txQ[0] = 24'h00A5C3; txQ[1] = 24'h001234; txQ[2] = 24'h00FFFF; txQ[3] = 24'h008001;
    txLen = 4;
    runSlots(4);
    for (int s = 0; s < 4; s++)
      check(capTx[s] == txQ[s], "R2 R6 left-justified 16-bit word", 32'(capTx[s]), 32'(txQ[s]));
    check(popCnt - popBase == 4, "R7 one pop per slot", 32'(popCnt - popBase), 4);
    check(trailBad == 0, "R7 trailing bits low", 32'(trailBad), 0);
    check(uflCnt == 0, "R8 no underflow with data", 32'(uflCnt), 0);
  endtask

  task automatic testTxI2sInv24();
    int u0cnt;
    u0cnt = uflCnt;
    setup(1'b1, 1'b1, 1'b0, 4'd8, 1'b0);
    txQ[0] = 24'hC00003; txQ[1] = 24'h5A5A5A; txQ[2] = 24'h800000; txQ[3] = 24'h7FFFFE;
    txLen = 4;
    runSlots(4);
    for (int s = 0; s < 4; s++)
      check(capTx[s] == txQ[s], "R3 R4 I2S 24-bit inverted bit clock", 32'(capTx[s]), 32'(txQ[s]));
    check(trailBad == 0, "R7 trailing bits low 24-bit", 32'(trailBad), 0);
    check(uflCnt == u0cnt, "R8 no underflow I2S", 32'(uflCnt - u0cnt), 0);
  endtask

  task automatic testUnderflow();
    int u0cnt;
    u0cnt = uflCnt;
    setup(1'b0, 1'b0, 1'b0, 4'd4, 1'b0);
    txQ[0] = 24'h0ABCDE; txQ[1] = 24'h0F0F01;
    txLen = 2;
    runSlots(4);
    check(capTx[0] == 24'h0ABCDE, "R6 20-bit word", 32'(capTx[0]), 32'h0ABCDE);
    check(capTx[1] == 24'h0F0F01, "R6 20-bit word", 32'(capTx[1]), 32'h0F0F01);
    check(capTx[2] == 24'h0F0F01, "R8 repeated word slot 2", 32'(capTx[2]), 32'h0F0F01);
    check(capTx[3] == 24'h0F0F01, "R8 repeated word slot 3", 32'(capTx[3]), 32'h0F0F01);
    check(uflCnt - u0cnt == 2, "R8 underflow count", 32'(uflCnt - u0cnt), 2);
    check(popCnt - popBase == 2, "R8 no pop when empty", 32'(popCnt - popBase), 2);
  endtask

  task automatic testRxI2s24();
    setup(1'b1, 1'b0, 1'b0, 4'd8, 1'b1);
    rxDrv[0] = 24'h123456; rxDrv[1] = 24'hFEDCBA; rxDrv[2] = 24'h000001; rxDrv[3] = 24'h800000;
    trailOne = 1'b1;
    txLen = 2; txQ[0] = 24'h111111; txQ[1] = 24'h222222;
    runSlots(4);
    check(pushCnt - pushBase == 4, "R9 push count", 32'(pushCnt - pushBase), 4);
    for (int s = 0; s < 4; s++) begin
      check(pushWord[s] == rxDrv[s], "R9 received word, trailing ones ignored", 32'(pushWord[s]), 32'(rxDrv[s]));
      check(pushLeft[s] == ((s % 2) == 0), "R3 left flag (frame low is left)", 32'(pushLeft[s]), 32'((s % 2) == 0));
    end
    check(trailBad == 0, "R9 txdOut low while receiving", 32'(trailBad), 0);
    check(popCnt - popBase == 0, "R9 no pop while receiving", 32'(popCnt - popBase), 0);
  endtask

  task automatic testRxLeftJustInv20();
    setup(1'b0, 1'b1, 1'b1, 4'd4, 1'b1);
    rxDrv[0] = 24'h0C0FFE; rxDrv[1] = 24'h03A5A5; rxDrv[2] = 24'h0FFFFF; rxDrv[3] = 24'h080000;
    trailOne = 1'b1;
    runSlots(4);
    check(pushCnt - pushBase == 4, "R5 push count", 32'(pushCnt - pushBase), 4);
    for (int s = 0; s < 4; s++) begin
      check(pushWord[s] == rxDrv[s], "R2 R6 left-justified 20-bit receive", 32'(pushWord[s]), 32'(rxDrv[s]));
      check(pushLeft[s] == ((s % 2) == 0), "R5 inverted frame polarity left flag", 32'(pushLeft[s]), 32'((s % 2) == 0));
    end
  endtask

  task automatic testOverflow();
    int o0cnt;
    o0cnt = oflCnt;
    setup(1'b0, 1'b0, 1'b0, 4'd0, 1'b1);
    rxDrv[0] = 24'h00BEEF; rxDrv[1] = 24'h00CAFE;
    rxFull = 1'b1;
    runSlots(2);
    check(oflCnt - o0cnt == 2, "R10 overflow count", 32'(oflCnt - o0cnt), 2);
    check(pushCnt - pushBase == 0, "R10 no push when full", 32'(pushCnt - pushBase), 0);
  endtask

  bit done = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    testReset();
    testTxLeftJust16();
    testTxI2sInv24();
    testUnderflow();
    testRxI2s24();
    testRxLeftJustInv20();
    testOverflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule